// File: doc/BRIEF.md
# SPI Slave Register-Access Front End

This block is an SPI slave that converts serial transactions from a host into byte accesses on a 64 KB register space. Each transaction starts with a short header that carries an address and a 3-bit command. After the header, the block streams data bytes. On reads, each byte comes from the next sequential register. On writes, each received byte is written to the next sequential register.

The header is two bytes by default, which reaches the lowest 8 KB. One command code adds a third header byte that supplies the top address bits, so the whole space becomes reachable. While the header is being shifted in, the block returns three bytes of interrupt status on MISO, so the host learns pending events without a separate access.

The SPI pins are oversampled by the system clock. SCK high and low phases must each last at least 6 system clock cycles. The register side is synchronous. `reg_rdata` must be valid in the cycle after a `reg_rd` pulse.

Top module: `spi_reg_frontend`

## Requirements
- R1: In the two-byte header, byte 0 holds address bits [12:5]. Byte 1 holds address bits [4:0] in bits [7:3] and the command in bits [2:0]. Address bits [15:13] are 0, and sequential addresses wrap inside the lowest 8 KB (0x1FFF is followed by 0x0000).
- R2: The command codes are: 3'b010 read, 3'b100 write, 3'b110 header extension, 3'b000 no operation. All other codes are reserved. `reg_rd` and `reg_wr` are never high together.
- R3: After an extension code in byte 1, header byte 2 holds address bits [15:13] in bits [7:5], the command in bits [4:2], and a reserved field in bits [1:0] that must be 00. Sequential addresses then cover the full 16-bit space.
- R4: MISO returns `irq_status[7:0]` during header byte 0 and `irq_status[15:8]` during header byte 1. In three-byte mode, it returns `irq_status[23:16]` during header byte 2.
- R5: Bits travel MSB first in SPI mode 3. MOSI is sampled on rising SCK, and MISO changes on falling SCK.
- R6: A write produces one single-cycle `reg_wr` per completed data byte, at the current address, and then advances the address. MISO is 0 during write data.
- R7: A read pulses `reg_rd` at the header address when the header completes. At every completed data byte, it pulses `reg_rd` again at the next address. Each data byte on MISO is the register at its own address, starting from its first bit. A transaction of N data bytes makes N+1 reads.
- R8: A no-operation code, a reserved code, or a nonzero reserved field makes the rest of the transaction produce no `reg_rd` or `reg_wr`, and MISO is 0.
- R9: Raising chip select at any point aborts the transaction. A partial byte is discarded, and the next transaction starts a fresh two-byte header.
- R10: After reset, `reg_wr`, `reg_rd` and `spi_miso` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock, idles high |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when idle |
| irq_status | input | 24 | Interrupt status returned during the header |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
Most internal faults show at the ports within the same transaction.

- A wrong header state or mode flag shows up within one byte time as the wrong interrupt-status byte on MISO, or as strobes at an address whose upper bits or 8 KB wrap are wrong.
- A wrong bit counter shifts every following byte by one or more bit positions. It also moves strobes to the wrong byte boundary, which shows as shifted write data or MISO bytes.
- A faulty abort path leaves stale state. This is seen only in the next transaction, as writes landing at addresses built from leftover header bits.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int LOW_W  = 13;
  localparam int IRQ_W  = 3 * BYTE_W;
  localparam int CMD_W  = 3;

  localparam logic [CMD_W-1:0] CMD_NOP   = 3'b000;
  localparam logic [CMD_W-1:0] CMD_READ  = 3'b010;
  localparam logic [CMD_W-1:0] CMD_WRITE = 3'b100;
  localparam logic [CMD_W-1:0] CMD_EXT   = 3'b110;

  typedef enum logic [2:0] {
    ST_H0,
    ST_H1,
    ST_H2,
    ST_RD,
    ST_WR,
    ST_IGN
  } fe_state_e;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_rf_shifter.sv
module spi_rf_shifter
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              cs_act,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sr;
  logic [BYTE_W-2:0] tx_sr;
  logic              sck_rise, sck_fall;

  assign cs_act   = ~cs_n_s;
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b1;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      miso      <= 1'b0;
    end else begin
      sck_q     <= sck_s;
      byte_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
        rx_sr   <= '0;
        tx_sr   <= '0;
        miso    <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_sr   <= {rx_sr[BYTE_W-3:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sr, mosi_s};
          end
        end
        if (sck_fall) begin
          if (bit_cnt == '0) {miso, tx_sr} <= tx_byte;
          else               {miso, tx_sr} <= {tx_sr, 1'b0};
        end
      end
    end
  end

  a_r5_single_done: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (!miso && !byte_done));
endmodule

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [IRQ_W-1:0]  irq_status,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd
);
  fe_state_e         st;
  logic              ext_q;
  logic [BYTE_W-1:0] addr_hi;
  logic [4:0]        addr_lo;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] nxt;
  logic [BYTE_W-1:0] rd_buf;
  logic              rd_wait;
  logic [CMD_W-1:0]  d_cmd;
  logic [ADDR_W-1:0] d_addr;
  logic              d_ok;

  always_comb begin
    if (st == ST_H2) begin
      d_cmd  = rx_byte[4:2];
      d_addr = {rx_byte[7:5], addr_hi, addr_lo};
      d_ok   = (rx_byte[1:0] == 2'b00);
    end else begin
      d_cmd  = rx_byte[2:0];
      d_addr = {3'b000, addr_hi, rx_byte[7:3]};
      d_ok   = 1'b1;
    end
    if (ext_q) nxt = cur + 1'b1;
    else       nxt = {3'b000, cur[LOW_W-1:0] + 1'b1};
  end

  always_comb begin
    unique case (st)
      ST_H0:   tx_byte = irq_status[7:0];
      ST_H1:   tx_byte = irq_status[15:8];
      ST_H2:   tx_byte = irq_status[23:16];
      ST_RD:   tx_byte = rd_buf;
      default: tx_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_H0;
      ext_q     <= 1'b0;
      addr_hi   <= '0;
      addr_lo   <= '0;
      cur       <= '0;
      rd_buf    <= '0;
      rd_wait   <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      rd_wait <= reg_rd;
      if (rd_wait) rd_buf <= reg_rdata;
      if (!cs_act) begin
        st    <= ST_H0;
        ext_q <= 1'b0;
      end else if (byte_done) begin
        unique case (st)
          ST_H0: begin
            addr_hi <= rx_byte;
            st      <= ST_H1;
          end
          ST_H1, ST_H2: begin
            if (st == ST_H1) addr_lo <= rx_byte[7:3];
            if (st == ST_H1 && rx_byte[2:0] == CMD_EXT) begin
              st    <= ST_H2;
              ext_q <= 1'b1;
            end else if (!d_ok) begin
              st <= ST_IGN;
            end else if (d_cmd == CMD_READ) begin
              st       <= ST_RD;
              cur      <= d_addr;
              reg_addr <= d_addr;
              reg_rd   <= 1'b1;
            end else if (d_cmd == CMD_WRITE) begin
              st  <= ST_WR;
              cur <= d_addr;
            end else begin
              st <= ST_IGN;
            end
          end
          ST_RD: begin
            cur      <= nxt;
            reg_addr <= nxt;
            reg_rd   <= 1'b1;
          end
          ST_WR: begin
            reg_addr  <= cur;
            reg_wdata <= rx_byte;
            reg_wr    <= 1'b1;
            cur       <= nxt;
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_excl: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));
  a_r6_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);
  a_r7_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);
  a_r1_low8k: assert property (@(posedge clk) disable iff (rst)
    ((reg_wr || reg_rd) && !ext_q) |-> (reg_addr[15:13] == 3'b000));
  a_r8_ign_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGN) |-> (!reg_wr && !reg_rd));
endmodule

// File: rtl/spi_reg_frontend.sv
module spi_reg_frontend
  import spi_rf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [IRQ_W-1:0]  irq_status,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [2:0]        pins_s;
  logic              cs_act, byte_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  spi_rf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_sck, spi_cs_n, spi_mosi}),
    .dout (pins_s)
  );

  spi_rf_shifter u_shift (
    .clk       (clk),
    .rst       (rst),
    .sck_s     (pins_s[2]),
    .cs_n_s    (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .tx_byte   (tx_byte),
    .cs_act    (cs_act),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  spi_rf_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .irq_status (irq_status),
    .reg_rdata  (reg_rdata),
    .tx_byte    (tx_byte),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd)
  );
endmodule

// File: tb/spi_reg_frontend_tb.sv
module spi_reg_frontend_tb;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sck = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso;
  logic [23:0] irq_status = 24'h0;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata = 8'h0;
  logic        reg_wr, reg_rd;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [15:0] wa [64];
  logic [7:0]  wd [64];
  logic [15:0] ra [64];
  int wr_n = 0, rd_n = 0;

  always #10 clk = ~clk;

  spi_reg_frontend u_dut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq_status(irq_status),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] mdl(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (reg_rd) reg_rdata <= mdl(reg_addr);
    if (!rst && reg_wr) begin
      wa[wr_n[5:0]] <= reg_addr;
      wd[wr_n[5:0]] <= reg_wdata;
      wr_n <= wr_n + 1;
    end
    if (!rst && reg_rd) begin
      ra[rd_n[5:0]] <= reg_addr;
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    @(negedge clk); spi_cs_n = 1'b0; wait_n(H);
  endtask

  task automatic cs_end();
    wait_n(H); spi_cs_n = 1'b1; wait_n(2 * H);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
    rx = 8'h0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_sck = 1'b0; spi_mosi = tx[i]; wait_n(H);
      rx[i] = spi_miso;
      spi_sck = 1'b1; wait_n(H);
    end
  endtask

  function automatic logic [7:0] h0(input logic [15:0] a);
    return a[12:5];
  endfunction
  function automatic logic [7:0] h1(input logic [15:0] a, input logic [2:0] c);
    return {a[4:0], c};
  endfunction
  function automatic logic [7:0] h2(input logic [15:0] a, input logic [2:0] c, input logic [1:0] r);
    return {a[15:13], c, r};
  endfunction

  task automatic t_reset();
    chk("R10 reg_wr", reg_wr, 0);
    chk("R10 reg_rd", reg_rd, 0);
    chk("R10 miso", spi_miso, 0);
  endtask

  task automatic t_write2();
    logic [7:0] rx;
    int b = wr_n;
    irq_status = 24'hC3A512;
    cs_begin();
    xfer(h0(16'h1234), rx); chk("R4 irq byte0", rx, 8'h12);
    xfer(h1(16'h1234, 3'b100), rx); chk("R4 irq byte1", rx, 8'hA5);
    xfer(8'h5E, rx); chk("R6 miso zero on write", rx, 0);
    xfer(8'h81, rx);
    xfer(8'h07, rx);
    cs_end();
    chk("R6 write count", wr_n - b, 3);
    chk("R1 write addr0", wa[b[5:0]], 16'h1234);
    chk("R5 write data0", wd[b[5:0]], 8'h5E);
    chk("R6 write addr1", wa[(b+1)%64], 16'h1235);
    chk("R5 write data1", wd[(b+1)%64], 8'h81);
    chk("R6 write addr2", wa[(b+2)%64], 16'h1236);
    chk("R6 write data2", wd[(b+2)%64], 8'h07);
  endtask

  task automatic t_wrap2();
    logic [7:0] rx;
    int b = wr_n;
    cs_begin();
    xfer(h0(16'h1FFF), rx); xfer(h1(16'h1FFF, 3'b100), rx);
    xfer(8'h11, rx); xfer(8'h22, rx);
    cs_end();
    chk("R1 wrap count", wr_n - b, 2);
    chk("R1 wrap addr0", wa[b[5:0]], 16'h1FFF);
    chk("R1 wrap addr1", wa[(b+1)%64], 16'h0000);
  endtask

  task automatic t_read2();
    logic [7:0] rx;
    int b = rd_n;
    cs_begin();
    xfer(h0(16'h0ABC), rx); xfer(h1(16'h0ABC, 3'b010), rx);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, rx);
      chk("R7 read data", rx, mdl(16'h0ABC + 16'(k)));
    end
    cs_end();
    chk("R7 read count", rd_n - b, 4);
    chk("R7 read first addr", ra[b[5:0]], 16'h0ABC);
  endtask

  task automatic t_read3();
    logic [7:0] rx;
    int b = rd_n;
    int w = wr_n;
    irq_status = 24'h9D4E71;
    cs_begin();
    xfer(h0(16'hE0F1), rx); chk("R4 ext irq0", rx, 8'h71);
    xfer(h1(16'hE0F1, 3'b110), rx); chk("R4 ext irq1", rx, 8'h4E);
    xfer(h2(16'hE0F1, 3'b010, 2'b00), rx); chk("R4 ext irq2", rx, 8'h9D);
    xfer(8'h00, rx); chk("R3 read data0", rx, mdl(16'hE0F1));
    xfer(8'h00, rx); chk("R3 read data1", rx, mdl(16'hE0F2));
    cs_end();
    chk("R3 read first addr", ra[b[5:0]], 16'hE0F1);
    chk("R2 no write on read", wr_n - w, 0);
  endtask

  task automatic t_write3();
    logic [7:0] rx;
    int b = wr_n;
    cs_begin();
    xfer(h0(16'hFFFF), rx); xfer(h1(16'hFFFF, 3'b110), rx);
    xfer(h2(16'hFFFF, 3'b100, 2'b00), rx);
    xfer(8'hAA, rx); xfer(8'h55, rx);
    cs_end();
    chk("R3 wr count", wr_n - b, 2);
    chk("R3 wr addr top", wa[b[5:0]], 16'hFFFF);
    chk("R3 wr addr wrap", wa[(b+1)%64], 16'h0000);
    chk("R3 wr data", wd[(b+1)%64], 8'h55);
  endtask

  task automatic t_ignore(input string tag, input bit ext, input logic [2:0] c, input logic [1:0] r);
    logic [7:0] rx;
    int bw = wr_n;
    int br = rd_n;
    logic [7:0] acc = 8'h0;
    cs_begin();
    xfer(h0(16'h0040), rx);
    if (ext) begin
      xfer(h1(16'h0040, 3'b110), rx);
      xfer(h2(16'h0040, c, r), rx);
    end else begin
      xfer(h1(16'h0040, c), rx);
    end
    for (int k = 0; k < 3; k++) begin
      xfer(8'hFF, rx); acc = acc | rx;
    end
    cs_end();
    chk({tag, " R8 miso zero"}, acc, 0);
    chk({tag, " R8 no write"}, wr_n - bw, 0);
    chk({tag, " R8 no read"}, rd_n - br, 0);
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    int b = wr_n;
    cs_begin();
    xfer(8'hFF, rx); xfer(8'hFF, rx, 4);
    spi_cs_n = 1'b1; wait_n(2 * H);
    cs_begin();
    xfer(h0(16'h0321), rx); xfer(h1(16'h0321, 3'b100), rx);
    xfer(8'h9C, rx); xfer(8'h33, rx, 5);
    cs_end();
    chk("R9 abort count", wr_n - b, 1);
    chk("R9 fresh header addr", wa[b[5:0]], 16'h0321);
    chk("R9 fresh header data", wd[b[5:0]], 8'h9C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    wait_n(4);
    t_reset();
    t_write2();
    t_wrap2();
    t_read2();
    t_read3();
    t_write3();
    t_ignore("nop", 1'b0, 3'b000, 2'b00);
    t_ignore("rsvcmd", 1'b0, 3'b011, 2'b00);
    t_ignore("rsvbits", 1'b1, 3'b100, 2'b01);
    t_ignore("extext", 1'b1, 3'b110, 2'b00);
    t_abort();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule